// File: doc/BRIEF.md
# Doubleword Shift-Left Execute Unit

This block is the execute slice for a single instruction: a 64-bit logical left shift whose count comes from a second register. It receives a 32-bit instruction word, the value to be shifted, the value that holds the shift count, and the current summary-overflow bit. One cycle after a valid strobe it presents a registered result. The result is a destination register write and, when the record bit asks for it, an update of condition field 0. Words that are not this instruction raise an illegal flag and write nothing.

The instruction word uses big-endian bit numbering, where bit 0 is the most significant bit. The shift amount is the low seven bits of the count operand. Counts from 64 to 127 therefore give a zero result rather than wrapping around. The shifter is a six-stage logarithmic barrel, and the seventh count bit forces the output to zero. The block never produces a carry.

Top module: `dw_shl_exec`

## Requirements
- R1: A valid word whose bits 0–5 (instr[31:26]) equal 31 and whose bits 21–30 (instr[10:1]) equal 27 is accepted. On the next clock, out_wr_en is 1 and out_dst equals bits 11–15 (instr[20:16]).
- R2: A valid word that fails the R1 match sets out_illegal to 1 on the next clock, with out_wr_en and out_cf_wr_en both 0.
- R3: For an accepted word with a shift amount n = cnt_val[6:0] below 64, out_result equals src_val shifted left by n. Bits leaving the MSB are lost and zeros enter at the LSB.
- R4: For an accepted word with n from 64 to 127, out_result is exactly 0. Bits 63..7 of cnt_val have no effect on the result.
- R5: For an accepted word with the record bit (instr[0]) set to 1, out_cf_wr_en is 1 and out_cf = {LT, GT, EQ, SO}, MSB first. LT, GT and EQ come from a signed comparison of the 64-bit result with zero, and exactly one of them is set. SO is a copy of so_in.
- R6: For an accepted word with the record bit set to 0, out_cf_wr_en is 0.
- R7: Outputs are registered. A clock edge without in_valid leaves out_wr_en, out_cf_wr_en and out_illegal at 0 for the following cycle.
- R8: While rst is high, out_wr_en, out_cf_wr_en and out_illegal are 0, and out_result is 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word, big-endian bit numbering |
| src_val | input | 64 | Value to shift |
| cnt_val | input | 64 | Value holding the shift count |
| so_in | input | 1 | Current summary-overflow bit |
| out_wr_en | output | 1 | Destination write enable |
| out_dst | output | 5 | Destination register index |
| out_result | output | 64 | Shifted result |
| out_cf_wr_en | output | 1 | Condition field write enable |
| out_cf | output | 4 | Condition field {LT, GT, EQ, SO} |
| out_illegal | output | 1 | Valid word did not match the instruction |

## Verification
The bench sweeps every count from 0 to 127 against all-ones, MSB-only, LSB-only, zero and random operands, with the record bit both clear and set.

- A design that took the count modulo 64 would return a shifted copy for counts 64 to 127 instead of zero.
- A shifter that mis-wired one barrel stage would fail only at counts that use that stage.
- Counts with junk in bits 7 and above expose a design that decodes too many count bits.
- The MSB-only operand at shift 0 and the LSB-only operand at shift 63 give negative results. A design that compared the result as unsigned would report GT there instead of LT.
- Near-miss words, with the right primary opcode but the wrong extended opcode or the reverse, catch a decoder that checks only one of the two fields.

// File: rtl/dwshl_pkg.sv
package dwshl_pkg;
    localparam int IW       = 32;
    localparam int RIDX_W   = 5;
    localparam int PRIM_W   = 6;
    localparam int EXT_W    = 10;
    localparam logic [PRIM_W-1:0] PRIM_OP = 6'd31;
    localparam logic [EXT_W-1:0]  EXT_OP  = 10'd27;

    // Decoded view of one instruction word
    typedef struct packed {
        logic              hit;
        logic              rec;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src_idx;
        logic [RIDX_W-1:0] cnt_idx;
    } dec_t;

    // Condition field, MSB first
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cfield_t;

    // Little-endian index of big-endian bit b in an IW-bit word
    function automatic int be2le(input int b);
        return IW - 1 - b;
    endfunction
endpackage

// File: rtl/dwshl_decode.sv
module dwshl_decode
    import dwshl_pkg::*;
(
    input  logic [IW-1:0] iw,
    output dec_t          dec
);
    logic [PRIM_W-1:0] prim;
    logic [EXT_W-1:0]  ext;

    always_comb begin
        prim        = iw[be2le(0)  -: PRIM_W];
        ext         = iw[be2le(21) -: EXT_W];
        dec.hit     = (prim == PRIM_OP) && (ext == EXT_OP);
        dec.rec     = iw[be2le(31)];
        dec.src_idx = iw[be2le(6)  -: RIDX_W];
        dec.dst     = iw[be2le(11) -: RIDX_W];
        dec.cnt_idx = iw[be2le(16) -: RIDX_W];
    end
endmodule

// File: rtl/dwshl_barrel.sv
module dwshl_barrel #(
    parameter int W = 64,
    localparam int SH = $clog2(W)
) (
    input  logic [W-1:0] din,
    input  logic [SH:0]  amt,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [0:SH];

    assign stg[0] = din;

    genvar k;
    generate
        for (k = 0; k < SH; k++) begin : g_stage
            assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
        end
    endgenerate

    // Top count bit: shift of W or more leaves nothing
    assign dout = amt[SH] ? '0 : stg[SH];
endmodule

// File: rtl/dwshl_cond.sv
module dwshl_cond
    import dwshl_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] r,
    input  logic         so,
    output cfield_t      cf
);
    always_comb begin
        cf.eq = (r == '0);
        cf.lt = r[W-1];
        cf.gt = !r[W-1] && !cf.eq;
        cf.so = so;
    end
endmodule

// File: rtl/dw_shl_exec.sv
module dw_shl_exec
    import dwshl_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int CNTW = $clog2(XLEN) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IW-1:0]     instr,
    input  logic [XLEN-1:0]   src_val,
    input  logic [XLEN-1:0]   cnt_val,
    input  logic              so_in,
    output logic              out_wr_en,
    output logic [RIDX_W-1:0] out_dst,
    output logic [XLEN-1:0]   out_result,
    output logic              out_cf_wr_en,
    output logic [3:0]        out_cf,
    output logic              out_illegal
);
    dec_t            dec;
    logic [XLEN-1:0] shifted;
    cfield_t         cfv;
    logic            unused_bits;

    // Register indices of the sources and upper count bits are not needed here
    assign unused_bits = ^{dec.src_idx, dec.cnt_idx, cnt_val[XLEN-1:CNTW]};

    dwshl_decode u_dec (
        .iw  (instr),
        .dec (dec)
    );

    dwshl_barrel #(.W(XLEN)) u_shf (
        .din  (src_val),
        .amt  (cnt_val[CNTW-1:0]),
        .dout (shifted)
    );

    dwshl_cond #(.W(XLEN)) u_cnd (
        .r  (shifted),
        .so (so_in),
        .cf (cfv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_wr_en    <= 1'b0;
            out_cf_wr_en <= 1'b0;
            out_illegal  <= 1'b0;
            out_dst      <= '0;
            out_result   <= '0;
            out_cf       <= '0;
        end else begin
            out_wr_en    <= in_valid && dec.hit;
            out_cf_wr_en <= in_valid && dec.hit && dec.rec;
            out_illegal  <= in_valid && !dec.hit;
            if (in_valid) begin
                out_dst    <= dec.dst;
                out_result <= dec.hit ? shifted : '0;
                out_cf     <= dec.hit ? cfv : '0;
            end
        end
    end
endmodule

// File: rtl/dw_shl_exec_chk.sv
module dw_shl_exec_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] src_val,
    input logic [XLEN-1:0] cnt_val,
    input logic            so_in,
    input logic            out_wr_en,
    input logic [4:0]      out_dst,
    input logic [XLEN-1:0] out_result,
    input logic            out_cf_wr_en,
    input logic [3:0]      out_cf,
    input logic            out_illegal
);
    localparam int SHB = $clog2(XLEN);

    p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_wr_en && !out_cf_wr_en));

    p_big_count_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt_val[SHB]) |=> (out_result == '0));

    p_cf_one_hot_r5: assert property (@(posedge clk) disable iff (rst)
        out_cf_wr_en |-> ($countones(out_cf[3:1]) == 1));

    p_cf_eq_zero_r5: assert property (@(posedge clk) disable iff (rst)
        out_cf_wr_en |-> (out_cf[1] == (out_result == '0)));

    p_cf_sign_r5: assert property (@(posedge clk) disable iff (rst)
        out_cf_wr_en |-> (out_cf[3] == out_result[XLEN-1]));

    p_so_copy_r5: assert property (@(posedge clk) disable iff (rst)
        out_cf_wr_en |-> (out_cf[0] == $past(so_in)));

    p_cf_needs_wr_r6: assert property (@(posedge clk) disable iff (rst)
        out_cf_wr_en |-> out_wr_en);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_wr_en && !out_cf_wr_en && !out_illegal));
endmodule

bind dw_shl_exec dw_shl_exec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/dw_shl_exec_tb.sv
module dw_shl_exec_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic [63:0] cnt_val = '0;
    logic        so_in = 1'b0;
    logic        out_wr_en;
    logic [4:0]  out_dst;
    logic [63:0] out_result;
    logic        out_cf_wr_en;
    logic [3:0]  out_cf;
    logic        out_illegal;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit          legal;
        bit          rec;
        logic [4:0]  dst;
        logic [63:0] res;
        logic [3:0]  cf;
        bit          big;
    } exp_t;

    exp_t sbq[$];

    always #10 clk = ~clk;

    dw_shl_exec u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .cnt_val(cnt_val), .so_in(so_in),
        .out_wr_en(out_wr_en), .out_dst(out_dst), .out_result(out_result),
        .out_cf_wr_en(out_cf_wr_en), .out_cf(out_cf), .out_illegal(out_illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit rec, input logic [4:0] rs,
                                       input logic [4:0] ra, input logic [4:0] rb);
        return {6'd31, rs, ra, rb, 10'd27, rec};
    endfunction

    // Driver: present one word at a falling edge and queue its expectation
    task automatic send(input logic [31:0] iw, input logic [63:0] a,
                        input logic [63:0] b, input bit so);
        exp_t e;
        int n;
        @(negedge clk);
        in_valid = 1'b1; instr = iw; src_val = a; cnt_val = b; so_in = so;
        n = int'(b[6:0]);
        e.legal = (iw[31:26] == 6'd31) && (iw[10:1] == 10'd27);
        e.rec = iw[0];
        e.dst = iw[20:16];
        e.big = (n >= 64);
        e.res = (n < 64) ? (a << n) : 64'd0;
        e.cf = {e.res[63], (!e.res[63] && e.res != 0), (e.res == 0), so};
        sbq.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops one expectation per captured strobe
    initial begin
        bit v;
        exp_t e;
        forever begin
            @(posedge clk);
            v = in_valid && !rst;
            #5;
            if (v) begin
                if (sbq.size() == 0) begin
                    chk("R1 queue underflow", 64'd1, 64'd0);
                end else begin
                    e = sbq.pop_front();
                    if (e.legal) begin
                        chk("R1 wr_en", out_wr_en, 1);
                        chk("R1 dst", out_dst, e.dst);
                        chk("R2 illegal clear", out_illegal, 0);
                        chk(e.big ? "R4 result" : "R3 result", out_result, e.res);
                        if (e.rec) begin
                            chk("R5 cf_wr_en", out_cf_wr_en, 1);
                            chk("R5 cf", out_cf, e.cf);
                        end else begin
                            chk("R6 cf_wr_en", out_cf_wr_en, 0);
                        end
                    end else begin
                        chk("R2 illegal", out_illegal, 1);
                        chk("R2 wr_en", out_wr_en, 0);
                        chk("R2 cf_wr_en", out_cf_wr_en, 0);
                    end
                end
            end else if (!rst) begin
                chk("R7 idle flags", {out_wr_en, out_cf_wr_en, out_illegal}, 0);
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_up();
    end

    initial begin
        logic [63:0] ops [5];
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 wr_en", out_wr_en, 0);
        chk("R8 cf_wr_en", out_cf_wr_en, 0);
        chk("R8 illegal", out_illegal, 0);
        chk("R8 result", out_result, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        ops[0] = '1;
        ops[1] = 64'h8000_0000_0000_0000;
        ops[2] = 64'h1;
        ops[3] = 64'h0;
        ops[4] = {$urandom, $urandom};
        for (int rc = 0; rc < 2; rc++) begin
            for (int o = 0; o < 5; o++) begin
                for (int n = 0; n < 128; n++) begin
                    send(mk(rc[0], 5'(n), 5'(n + o), 5'(o)), ops[o], 64'(n), n[0] ^ o[0]);
                end
                idle();
            end
        end

        // Random operands with junk above the seven count bits (R4)
        for (int i = 0; i < 200; i++) begin
            logic [63:0] junk;
            junk = {$urandom, $urandom};
            send(mk(i[0], 5'($urandom), 5'($urandom), 5'($urandom)),
                 {$urandom, $urandom}, junk, i[1]);
            if (i % 17 == 0) idle();
        end

        // Near-miss and foreign words (R2)
        send({6'd31, 15'h1234, 10'd28, 1'b0}, '1, 64'd3, 1'b0);
        send({6'd31, 15'h0421, 10'd26, 1'b1}, '1, 64'd3, 1'b0);
        send({6'd30, 15'h0421, 10'd27, 1'b1}, '1, 64'd3, 1'b1);
        send({6'd63, 15'h7fff, 10'd27, 1'b0}, '1, 64'd3, 1'b1);
        send({6'd31, 15'h0421, 10'd539, 1'b1}, '1, 64'd3, 1'b1);
        send(32'h7C00_0036, 64'hDEAD_BEEF_0000_0001, 64'd4, 1'b1);
        send(32'h7C00_0037, 64'h4000_0000_0000_0000, 64'd1, 1'b1);
        idle();
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule